// File: doc/BRIEF.md
# Clock Source Start/Stop Controller

This block sequences three clock sources (a crystal oscillator, a PLL and a low-frequency clock) through start and stop requests. It also runs two one-shot jobs, an RC calibration and a crystal tuning pass. Settle counters stand in for real oscillators. Each source reports two things: the state software asked for (run) and the state the hardware has reached (stat).

Completions set sticky event flags. A small register write port lets software set or clear interrupt-enable bits, clear event flags and choose the low-frequency source. The pending vector and the level interrupt follow the flags and the mask.

Top module: `clkctl_top`

## Requirements
- R1: After reset, every source state is 0, and run, stat, event flags, enable mask, pending, interrupt, source copy and status source field are all 0.
- R2: A start strobe is accepted when a source is Stopped (code 0) or Stopping (code 3). On acceptance the state becomes Starting (code 1) and the run bit becomes 1 on the next clock.
- R3: A start strobe has no effect while a source is Starting or Started (code 2). A stop strobe has no effect while a source is Stopped or Stopping.
- R4: A source that is Starting becomes Started exactly DLY clocks after the start is accepted. Its stat bit is then set and its started event is raised: bit 0 for the oscillator, bit 1 for the PLL, bit 2 for the low-frequency clock.
- R5: An accepted stop moves a Starting or Started source to Stopping and clears its run bit. DLY clocks later the source is Stopped, its stat bit is cleared, and no event is raised.
- R6: The run bit keeps its value after a start or a stop completes. It changes only when the opposite strobe is accepted.
- R7: An accepted low-frequency start copies the source-select register into the copy output. Start completion loads that copy into the status source field. A stop keeps the field unchanged, and later writes to the select register leave the copy unchanged.
- R8: Completion of an oscillator start also raises the tuned event (bit 4).
- R9: A calibration strobe is accepted only when calibration is idle and raises done (bit 3) CAL_DLY clocks later; a strobe while busy neither restarts nor extends it. Tuning behaves the same with TUNE_DLY and bit 4. Bits 5 and 6 are never set.
- R10: Pending equals the event flags ANDed with the enable mask. The interrupt is high exactly when any pending bit is set.
- R11: Register writes work as follows. Address 0 sets the enable bits where the write data is 1. Address 1 clears them. Address 2 loads the source select from the low data bits. Address 4+k with data bit 0 equal to 0 clears event k. Data bit 0 equal to 1 at that address has no effect.
- R12: A start accepted while Stopping returns the source to Starting with the full delay reloaded, and the stat bit stays set in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 3 | Start strobes, bit 0 oscillator, 1 PLL, 2 low-frequency |
| stop_i | input | 3 | Stop strobes, same bit order |
| cal_i | input | 1 | Calibration strobe |
| tune_i | input | 1 | Tuning strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register write address |
| reg_wdata_i | input | 7 | Register write data |
| src_state_o | output | 6 | Two-bit state per source, source s at bits 2s+1:2s |
| run_o | output | 3 | Requested-on bit per source |
| stat_o | output | 3 | Achieved-on bit per source |
| lf_copy_o | output | 2 | Source select captured at the last low-frequency start |
| lf_stat_src_o | output | 2 | Source field of the low-frequency status |
| event_o | output | 7 | Sticky event flags |
| inten_o | output | 7 | Interrupt enable mask |
| intpend_o | output | 7 | Pending interrupts |
| irq_o | output | 1 | Level interrupt |

## Verification
A state machine stuck in the wrong state shows on src_state_o on the clock after the strobe. A settle counter that is wrongly loaded or reloaded moves the completion edge. The bench samples one clock before and on the expected completion, so an error of one cycle in either direction is reported. A lost or spurious event shows on event_o and on irq_o once the mask is set. A wrong capture of the source select stays visible on lf_copy_o and lf_stat_src_o until the next start.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_RAMP = 2'd1,
    SRC_ON   = 2'd2,
    SRC_HALT = 2'd3
  } src_state_e;

  localparam int NUM_SRC  = 3;
  localparam int SRC_XO   = 0;
  localparam int SRC_PLL  = 1;
  localparam int SRC_LF   = 2;

  localparam int NUM_EVT  = 7;
  localparam int EV_XO    = 0;
  localparam int EV_PLL   = 1;
  localparam int EV_LF    = 2;
  localparam int EV_CAL   = 3;
  localparam int EV_TUNED = 4;
  localparam int EV_TERR  = 5;
  localparam int EV_TFAIL = 6;

  localparam int ADDR_W   = 4;
  localparam int REG_W    = NUM_EVT;
  localparam logic [ADDR_W-1:0] A_INTEN_SET = 4'd0;
  localparam logic [ADDR_W-1:0] A_INTEN_CLR = 4'd1;
  localparam logic [ADDR_W-1:0] A_LF_SEL    = 4'd2;
  localparam logic [ADDR_W-1:0] A_EVT_BASE  = 4'd4;
endpackage

// File: rtl/clkctl_src_fsm.sv
module clkctl_src_fsm
  import clkctl_pkg::*;
#(
  parameter int DLY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  output src_state_e state_o,
  output logic       run_o,
  output logic       stat_o,
  output logic       up_done_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DLY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  src_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic run_q, run_d, stat_q, stat_d;
  logic start_ok, stop_ok, expire, dn_done, cnt_en;

  always_comb begin
    start_ok  = start_i && (st_q == SRC_OFF || st_q == SRC_HALT);
    stop_ok   = stop_i && (st_q == SRC_RAMP || st_q == SRC_ON);
    expire    = (cnt_q == ONE);
    up_done_o = (st_q == SRC_RAMP) && expire && !stop_ok;
    dn_done   = (st_q == SRC_HALT) && expire && !start_ok;
    cnt_en    = start_ok || stop_ok || (cnt_q != '0);
    st_d   = st_q;
    run_d  = run_q;
    stat_d = stat_q;
    cnt_d  = cnt_q - ONE;
    if (start_ok) begin
      st_d  = SRC_RAMP;
      run_d = 1'b1;
      cnt_d = LOAD;
    end else if (stop_ok) begin
      st_d  = SRC_HALT;
      run_d = 1'b0;
      cnt_d = LOAD;
    end else if (up_done_o) begin
      st_d   = SRC_ON;
      stat_d = 1'b1;
    end else if (dn_done) begin
      st_d   = SRC_OFF;
      stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SRC_OFF;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      stat_q <= stat_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign run_o   = run_q;
  assign stat_o  = stat_q;

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> (st_q == SRC_RAMP) && run_q); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && st_q == SRC_ON) |=> (st_q == SRC_ON) && run_q); // R3
  AST_STOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i && st_q == SRC_OFF) |=> (st_q == SRC_OFF) && !run_q); // R3
  AST_UP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SRC_RAMP && expire && !stop_i) |=> (st_q == SRC_ON) && stat_q); // R4
  AST_DOWN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SRC_HALT && expire && !start_i) |=> (st_q == SRC_OFF) && !stat_q); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i) |=> $stable(run_q)); // R6
endmodule

// File: rtl/clkctl_oneshot.sv
module clkctl_oneshot #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic done_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DLY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic accept, cnt_en;

  always_comb begin
    accept = req_i && !busy_q;
    done_o = busy_q && (cnt_q == ONE);
    cnt_en = accept || busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q - ONE;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (done_o) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != ONE && req_i) |=> busy_q && (cnt_q == $past(cnt_q) - ONE)); // R9
endmodule

// File: rtl/clkctl_irq.sv
module clkctl_irq
  import clkctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EVT-1:0] evt_set_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_EVT-1:0] evt_o,
  output logic [NUM_EVT-1:0] inten_o,
  output logic [NUM_EVT-1:0] intpend_o,
  output logic              irq_o
);
  logic [NUM_EVT-1:0] evt_q, evt_d, clr, inten_q, inten_d;
  logic inten_en;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    assign clr[k]   = wr_i && (addr_i == A_EVT_BASE + ADDR_W'(k)) && !wdata_i[0];
    assign evt_d[k] = evt_set_i[k] | (evt_q[k] & ~clr[k]);

    AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_q[k] && !clr[k]) |=> evt_q[k]); // R11
  end

  always_comb begin
    inten_en = wr_i && (addr_i == A_INTEN_SET || addr_i == A_INTEN_CLR);
    inten_d  = (addr_i == A_INTEN_SET) ? (inten_q | wdata_i) : (inten_q & ~wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      inten_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (inten_en) inten_q <= inten_d;
    end
  end

  assign evt_o     = evt_q;
  assign inten_o   = inten_q;
  assign intpend_o = evt_q & inten_q;
  assign irq_o     = |intpend_o;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_INTEN_SET) |=> ((inten_q & $past(wdata_i)) == $past(wdata_i))); // R11
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_INTEN_CLR) |=> ((inten_q & $past(wdata_i)) == '0)); // R11
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int XO_DLY    = 8,
  parameter int PLL_DLY   = 5,
  parameter int LF_DLY    = 12,
  parameter int CAL_DLY   = 6,
  parameter int TUNE_DLY  = 4,
  parameter int SRC_SEL_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SRC-1:0]     start_i,
  input  logic [NUM_SRC-1:0]     stop_i,
  input  logic                   cal_i,
  input  logic                   tune_i,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [REG_W-1:0]       reg_wdata_i,
  output logic [2*NUM_SRC-1:0]   src_state_o,
  output logic [NUM_SRC-1:0]     run_o,
  output logic [NUM_SRC-1:0]     stat_o,
  output logic [SRC_SEL_W-1:0]   lf_copy_o,
  output logic [SRC_SEL_W-1:0]   lf_stat_src_o,
  output logic [NUM_EVT-1:0]     event_o,
  output logic [NUM_EVT-1:0]     inten_o,
  output logic [NUM_EVT-1:0]     intpend_o,
  output logic                   irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NUM_SRC-1:0] up_done;
  logic cal_done, tune_done;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int D = (g == SRC_XO) ? XO_DLY : (g == SRC_PLL) ? PLL_DLY : LF_DLY;
    src_state_e st;
    clkctl_src_fsm #(.DLY(D)) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .start_i  (start_i[g]),
      .stop_i   (stop_i[g]),
      .state_o  (st),
      .run_o    (run_o[g]),
      .stat_o   (stat_o[g]),
      .up_done_o(up_done[g])
    );
    assign src_state_o[2*g +: 2] = st;
  end

  clkctl_oneshot #(.DLY(CAL_DLY)) u_cal (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(cal_i), .done_o(cal_done));
  clkctl_oneshot #(.DLY(TUNE_DLY)) u_tune (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(tune_i), .done_o(tune_done));

  // Low-frequency source select, capture at start, status field at completion.
  logic [SRC_SEL_W-1:0] sel_q, copy_q, stsrc_q;
  logic sel_en, copy_en;

  always_comb begin
    sel_en  = reg_wr_i && (reg_addr_i == A_LF_SEL);
    copy_en = start_i[SRC_LF] && !run_o[SRC_LF];  // run is 0 exactly in Stopped/Stopping
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      copy_q  <= '0;
      stsrc_q <= '0;
    end else begin
      if (sel_en)           sel_q   <= reg_wdata_i[SRC_SEL_W-1:0];
      if (copy_en)          copy_q  <= sel_q;
      if (up_done[SRC_LF])  stsrc_q <= copy_q;
    end
  end

  assign lf_copy_o     = copy_q;
  assign lf_stat_src_o = stsrc_q;

  logic [NUM_EVT-1:0] evt_set;
  always_comb begin
    evt_set           = '0;
    evt_set[EV_XO]    = up_done[SRC_XO];
    evt_set[EV_PLL]   = up_done[SRC_PLL];
    evt_set[EV_LF]    = up_done[SRC_LF];
    evt_set[EV_CAL]   = cal_done;
    evt_set[EV_TUNED] = tune_done | up_done[SRC_XO];
  end

  clkctl_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .evt_set_i(evt_set),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .evt_o    (event_o),
    .inten_o  (inten_o),
    .intpend_o(intpend_o),
    .irq_o    (irq_o)
  );

  AST_LF_SRC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(stat_o[SRC_LF]) |-> $stable(stsrc_q)); // R7
  AST_LF_COPY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_o[SRC_LF] |=> $stable(copy_q)); // R7
  AST_NO_TUNE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (event_o[EV_TERR] == 1'b0) && (event_o[EV_TFAIL] == 1'b0)); // R9
endmodule

// File: tb/clkctl_top_tb_top.sv
module clkctl_top_tb_top;
  localparam int XO = 8, PLL = 5, LF = 12, CAL = 6, TUNE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] start_v, stop_v;
  logic cal, tune, wr;
  logic [3:0] addr;
  logic [6:0] wdata;
  logic [5:0] src_state;
  logic [2:0] run, stat;
  logic [1:0] lf_copy, lf_stsrc;
  logic [6:0] evt, inten, intpend;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  clkctl_top #(.XO_DLY(XO), .PLL_DLY(PLL), .LF_DLY(LF), .CAL_DLY(CAL),
               .TUNE_DLY(TUNE), .SRC_SEL_W(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v), .stop_i(stop_v),
    .cal_i(cal), .tune_i(tune), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .src_state_o(src_state), .run_o(run), .stat_o(stat),
    .lf_copy_o(lf_copy), .lf_stat_src_o(lf_stsrc), .event_o(evt),
    .inten_o(inten), .intpend_o(intpend), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] st(int s);
    return src_state[2*s +: 2];
  endfunction

  task automatic pulse_start(int s);
    @(negedge clk) start_v[s] = 1'b1;
    @(negedge clk) start_v[s] = 1'b0;
  endtask
  task automatic pulse_stop(int s);
    @(negedge clk) stop_v[s] = 1'b1;
    @(negedge clk) stop_v[s] = 1'b0;
  endtask
  task automatic pulse_cal();
    @(negedge clk) cal = 1'b1;
    @(negedge clk) cal = 1'b0;
  endtask
  task automatic pulse_tune();
    @(negedge clk) tune = 1'b1;
    @(negedge clk) tune = 1'b0;
  endtask
  task automatic wr_reg(logic [3:0] a, logic [6:0] d);
    @(negedge clk) begin wr = 1'b1; addr = a; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", src_state, 0);
    chk("R1 run/stat", {run, stat}, 0);
    chk("R1 events", evt, 0);
    chk("R1 mask/pend", {inten, intpend}, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lf fields", {lf_copy, lf_stsrc}, 0);
  endtask

  task automatic t_xo();
    pulse_start(0);
    chk("R2 xo starting", st(0), 1);
    chk("R2 xo run", run[0], 1);
    repeat (XO - 1) @(negedge clk);
    chk("R4 xo not early", st(0), 1);
    chk("R4 xo no early event", evt[0], 0);
    @(negedge clk);
    chk("R4 xo started", st(0), 2);
    chk("R4 xo stat", stat[0], 1);
    chk("R4 xo event", evt[0], 1);
    chk("R8 xo tuned", evt[4], 1);
    pulse_start(0);
    chk("R3 start ignored in started", st(0), 2);
    chk("R6 run kept after start", run[0], 1);
    wr_reg(4'd4, 7'h01);
    chk("R11 clear data 1 ignored", evt[0], 1);
    wr_reg(4'd4, 7'h00);
    wr_reg(4'd8, 7'h00);
    chk("R11 events cleared", {evt[4], evt[0]}, 0);
    pulse_stop(0);
    chk("R5 xo stopping", st(0), 3);
    chk("R5 xo run cleared", run[0], 0);
    pulse_stop(0);
    chk("R3 stop ignored in stopping", st(0), 3);
    repeat (XO - 3) @(negedge clk);
    chk("R5 xo still stopping", st(0), 3);
    @(negedge clk);
    chk("R5 xo stopped", st(0), 0);
    chk("R5 xo stat cleared", stat[0], 0);
    chk("R5 no stop event", evt[0], 0);
    chk("R6 run kept after stop", run[0], 0);
    pulse_stop(0);
    chk("R3 stop ignored in stopped", {st(0), run[0]}, 0);
  endtask

  task automatic t_restart();
    pulse_start(1);
    repeat (PLL - 1) @(negedge clk);
    @(negedge clk);
    chk("R4 pll started", {st(1), stat[1], evt[1]}, {2'd2, 1'b1, 1'b1});
    pulse_stop(1);
    pulse_start(1);
    chk("R12 back to starting", st(1), 1);
    chk("R12 stat held", stat[1], 1);
    chk("R12 run set", run[1], 1);
    repeat (PLL - 1) @(negedge clk);
    chk("R12 full delay reloaded", st(1), 1);
    @(negedge clk);
    chk("R12 restart completes", st(1), 2);
  endtask

  task automatic t_lf();
    wr_reg(4'd2, 7'h02);
    pulse_start(2);
    chk("R7 copy at start", lf_copy, 2);
    chk("R7 field before completion", lf_stsrc, 0);
    wr_reg(4'd2, 7'h01);
    repeat (LF - 3) @(negedge clk);
    chk("R4 lf not early", st(2), 1);
    @(negedge clk);
    chk("R4 lf started", {st(2), stat[2], evt[2]}, {2'd2, 1'b1, 1'b1});
    chk("R7 field loaded", lf_stsrc, 2);
    chk("R7 copy frozen", lf_copy, 2);
    pulse_stop(2);
    repeat (LF - 1) @(negedge clk);
    @(negedge clk);
    chk("R5 lf stopped", {st(2), stat[2]}, 0);
    chk("R7 field kept on stop", lf_stsrc, 2);
    pulse_start(2);
    chk("R7 new copy", lf_copy, 1);
    chk("R7 field until completion", lf_stsrc, 2);
  endtask

  task automatic t_jobs();
    wr_reg(4'd7, 7'h00);
    wr_reg(4'd8, 7'h00);
    pulse_cal();
    pulse_cal();
    repeat (CAL - 3) @(negedge clk);
    chk("R9 cal not early", evt[3], 0);
    @(negedge clk);
    chk("R9 cal done on time", evt[3], 1);
    pulse_tune();
    pulse_tune();
    repeat (TUNE - 3) @(negedge clk);
    chk("R9 tune not early", evt[4], 0);
    @(negedge clk);
    chk("R9 tuned", evt[4], 1);
    chk("R9 fault events never set", evt[6:5], 0);
  endtask

  task automatic t_irq();
    chk("R10 masked", {intpend, irq}, 0);
    wr_reg(4'd0, 7'h08);
    chk("R11 mask set", inten, 7'h08);
    chk("R10 pending cal", intpend, 7'h08);
    chk("R10 irq high", irq, 1);
    wr_reg(4'd1, 7'h08);
    chk("R11 mask cleared", inten, 0);
    chk("R10 irq low", irq, 0);
    wr_reg(4'd0, 7'h10);
    chk("R10 pending tuned", intpend, 7'h10);
    wr_reg(4'd8, 7'h00);
    chk("R11 event cleared", evt[4], 0);
    chk("R10 irq follows", irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_v = '0; stop_v = '0; cal = 1'b0; tune = 1'b0;
    wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_xo();
    t_restart();
    t_lf();
    t_jobs();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule